// File: doc/BRIEF.md
# Supervisor Status and Stack Pointer Bank

This block keeps the processor's 16-bit status word together with three banked stack pointers: one for user mode, one for interrupt handling and one master pointer. Only one of the three is live at any time and is presented as register A7. When a new status word changes the supervisor bit (bit 13) or the master bit (bit 12), the block parks the live A7 in the bank that was active and loads A7 from the bank that becomes active. No other write is needed for the switch.

A control-register port gives direct access to the three banked pointers and to a vector base register. A read of the pointer that is currently active returns the live A7, and a write to it also lands in A7. A single-cycle exception-entry input forces supervisor mode and clears the trace and master bits. Condition-code arithmetic and exception frame stacking are handled elsewhere.

Top module: `mode_stack_bank`

## Requirements
- R1: After a synchronous active-low reset the status word is 0x2700 and A7, all three pointer banks and the vector base read as zero.
- R2: A status write stores the word with bits 11 and 7:5 forced to zero. Those bits always read as zero. Bit 15 and bit 14 are trace bits, bit 13 is S, bit 12 is M, bits 10:8 are the interrupt mask and bits 4:0 are the condition codes.
- R3: A status write that clears S saves the old A7 to the master bank if the old M was 1, or to the interrupt bank otherwise. A7 is then loaded from the user bank.
- R4: A status write that sets S from 0 saves A7 to the user bank. A7 is then loaded from the master bank if the new M is 1, or from the interrupt bank otherwise.
- R5: A status write that keeps S at 1 and toggles M exchanges A7 with the master and interrupt banks. A status write that changes neither S nor M leaves A7 and the banks unchanged.
- R6: When a status write and an A7 write happen in the same cycle, the bank switch happens first and saves the old A7. The written value then becomes the new live A7.
- R7: An A7 write without a mode change only replaces A7. A cycle with no write and no exception holds A7 and the status word.
- R8: The control numbers are 0x800 for the user bank, 0x801 for the vector base, 0x803 for the master bank and 0x804 for the interrupt bank. A read of the active pointer returns the live A7 (user when S=0, master when S=1 and M=1, interrupt when S=1 and M=0). An inactive pointer reads from its bank.
- R9: A control write to the active pointer also replaces A7. A control write to an inactive pointer changes only its bank.
- R10: For any other control number, cr_illegal is high while cr_rd or cr_wr is asserted, cr_rdata is zero, and a write to it changes no state.
- R11: Exception entry sets S and clears T1, T0 and M, keeping bits 10:0. If S was 0, the user bank receives A7 and A7 is loaded from the master bank if M was 1, or from the interrupt bank otherwise. If S was already 1, A7 is left as it is.
- R12: Per cycle the priority is: exception entry, then the status and A7 writes, then a control write. A lower-priority write in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_entry | input | 1 | Exception entry pulse |
| sr_wr | input | 1 | Status word write strobe |
| sr_wdata | input | 16 | New status word |
| sr_q | output | 16 | Current status word |
| a7_wr | input | 1 | A7 write strobe |
| a7_wdata | input | 32 | New A7 value |
| a7_q | output | 32 | Live stack pointer |
| cr_wr | input | 1 | Control register write strobe |
| cr_rd | input | 1 | Control register read strobe |
| cr_num | input | 12 | Control register number |
| cr_wdata | input | 32 | Control register write data |
| cr_rdata | output | 32 | Control register read data (combinational) |
| cr_illegal | output | 1 | Unknown control number on an access |

## Verification
The bench goes after every transition of S and M in both directions. A design that saved to the wrong bank would show up later as a stale pointer when the mode returns. It also combines a status write with an A7 write in the same cycle; a design that applied the A7 write first would park the new value in the old bank instead of making it live. Control writes to the active and inactive pointers, and exception entry from user and master modes, catch a design that fails to mirror A7 or that swaps when it should not. Illegal numbers catch a design that still writes or drives read data.

// File: rtl/msb_pkg.sv
// Package: shared constants and types of the status/stack pointer bank.
// Assumes a 16-bit status word with S at bit 13 and M at bit 12.
package msb_pkg;
    localparam int SR_W       = 16;
    localparam int S_BIT      = 13;
    localparam int M_BIT      = 12;
    localparam logic [SR_W-1:0] SR_KEEP_MASK  = 16'hF71F;
    localparam logic [SR_W-1:0] SR_RESET_VAL  = 16'h2700;
    localparam logic [SR_W-1:0] SR_EXC_CLEAR  = 16'h0FFF;

    localparam logic [11:0] CRN_USER   = 12'h800;
    localparam logic [11:0] CRN_VBASE  = 12'h801;
    localparam logic [11:0] CRN_MASTER = 12'h803;
    localparam logic [11:0] CRN_INTR   = 12'h804;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_USER,
        SEL_VBASE,
        SEL_MASTER,
        SEL_INTR
    } cr_sel_e;
endpackage

// File: rtl/msb_status_reg.sv
// Status word register. Computes the next status word from the exception
// and status-write requests and holds it. Assumes the caller resolves
// priority (exc_go and sr_go are never both high).
module msb_status_reg
    import msb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_go,
    input  logic            sr_go,
    input  logic [SR_W-1:0] sr_wdata,
    output logic [SR_W-1:0] sr_q,
    output logic [SR_W-1:0] sr_n
);
    // Next status word: exception forces S and clears T1/T0/M, write masks unused bits
    always_comb begin
        sr_n = sr_q;
        if (exc_go) begin
            sr_n = sr_q & SR_EXC_CLEAR;
            sr_n[S_BIT] = 1'b1;
        end else if (sr_go) begin
            sr_n = sr_wdata & SR_KEEP_MASK;
        end
    end

    // Status word storage
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= SR_RESET_VAL;
        else        sr_q <= sr_n;
    end
endmodule

// File: rtl/msb_sp_bank.sv
// Stack pointer bank: live A7 plus user, interrupt and master banks.
// Exchanges A7 with the banks on mode changes, then applies A7 writes,
// then control writes. Assumes the caller makes the go signals exclusive
// per the block priority (exc_go excludes the others, cr_go excludes sr/a7).
module msb_sp_bank
    import msb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              old_s,
    input  logic              old_m,
    input  logic              new_s,
    input  logic              new_m,
    input  logic              exc_go,
    input  logic              sr_go,
    input  logic              a7_go,
    input  logic [ADDR_W-1:0] a7_wdata,
    input  logic              cr_go,
    input  cr_sel_e           cr_sel,
    input  logic [ADDR_W-1:0] cr_wdata,
    output logic [ADDR_W-1:0] a7_q,
    output logic [ADDR_W-1:0] usp_q,
    output logic [ADDR_W-1:0] isp_q,
    output logic [ADDR_W-1:0] msp_q
);
    logic [ADDR_W-1:0] a7_n, usp_n, isp_n, msp_n;

    // Next-state of A7 and the banks
    always_comb begin
        a7_n  = a7_q;
        usp_n = usp_q;
        isp_n = isp_q;
        msp_n = msp_q;
        if (exc_go) begin
            if (!old_s) begin
                usp_n = a7_q;
                a7_n  = old_m ? msp_q : isp_q;
            end
        end else begin
            if (sr_go) begin
                if (old_s && !new_s) begin
                    if (old_m) msp_n = a7_q;
                    else       isp_n = a7_q;
                    a7_n = usp_q;
                end else if (!old_s && new_s) begin
                    usp_n = a7_q;
                    a7_n  = new_m ? msp_q : isp_q;
                end else if (old_s && (old_m != new_m)) begin
                    if (old_m) begin
                        msp_n = a7_q;
                        a7_n  = isp_q;
                    end else begin
                        isp_n = a7_q;
                        a7_n  = msp_q;
                    end
                end
            end
            if (a7_go) a7_n = a7_wdata;
            if (cr_go) begin
                case (cr_sel)
                    SEL_USER: begin
                        usp_n = cr_wdata;
                        if (!old_s) a7_n = cr_wdata;
                    end
                    SEL_MASTER: begin
                        msp_n = cr_wdata;
                        if (old_s && old_m) a7_n = cr_wdata;
                    end
                    SEL_INTR: begin
                        isp_n = cr_wdata;
                        if (old_s && !old_m) a7_n = cr_wdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Pointer storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a7_q  <= '0;
            usp_q <= '0;
            isp_q <= '0;
            msp_q <= '0;
        end else begin
            a7_q  <= a7_n;
            usp_q <= usp_n;
            isp_q <= isp_n;
            msp_q <= msp_n;
        end
    end
endmodule

// File: rtl/msb_ctrl_regs.sv
// Control register port: decodes the number, holds the vector base and
// muxes read data, returning live A7 for the active pointer. Assumes
// vb_go is only raised for a legal, unblocked write.
module msb_ctrl_regs
    import msb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CRN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CRN_W-1:0]  cr_num,
    input  logic              cr_rd,
    input  logic              cr_wr,
    input  logic              vb_go,
    input  logic [ADDR_W-1:0] cr_wdata,
    input  logic              cur_s,
    input  logic              cur_m,
    input  logic [ADDR_W-1:0] a7_q,
    input  logic [ADDR_W-1:0] usp_q,
    input  logic [ADDR_W-1:0] isp_q,
    input  logic [ADDR_W-1:0] msp_q,
    output cr_sel_e           cr_sel,
    output logic [ADDR_W-1:0] cr_rdata,
    output logic              cr_illegal
);
    localparam logic [CRN_W-1:0] N_USER   = CRN_W'(CRN_USER);
    localparam logic [CRN_W-1:0] N_VBASE  = CRN_W'(CRN_VBASE);
    localparam logic [CRN_W-1:0] N_MASTER = CRN_W'(CRN_MASTER);
    localparam logic [CRN_W-1:0] N_INTR   = CRN_W'(CRN_INTR);

    logic [ADDR_W-1:0] vbase_q;

    // Number decode
    always_comb begin
        case (cr_num)
            N_USER:   cr_sel = SEL_USER;
            N_VBASE:  cr_sel = SEL_VBASE;
            N_MASTER: cr_sel = SEL_MASTER;
            N_INTR:   cr_sel = SEL_INTR;
            default:  cr_sel = SEL_NONE;
        endcase
    end

    // Illegal flag on any access to an unknown number
    assign cr_illegal = (cr_rd || cr_wr) && (cr_sel == SEL_NONE);

    // Read mux, live A7 for the active pointer
    always_comb begin
        cr_rdata = '0;
        if (cr_rd) begin
            case (cr_sel)
                SEL_USER:   cr_rdata = !cur_s            ? a7_q : usp_q;
                SEL_VBASE:  cr_rdata = vbase_q;
                SEL_MASTER: cr_rdata = (cur_s && cur_m)  ? a7_q : msp_q;
                SEL_INTR:   cr_rdata = (cur_s && !cur_m) ? a7_q : isp_q;
                default:    cr_rdata = '0;
            endcase
        end
    end

    // Vector base storage
    always_ff @(posedge clk) begin
        if (!rst_n)     vbase_q <= '0;
        else if (vb_go) vbase_q <= cr_wdata;
    end
endmodule

// File: rtl/mode_stack_bank.sv
// Top: status word with three banked stack pointers and a control port.
// Resolves per-cycle priority (exception, then status/A7 writes, then
// control write) and connects the status, bank and control submodules.
module mode_stack_bank
    import msb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CRN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_entry,
    input  logic              sr_wr,
    input  logic [15:0]       sr_wdata,
    output logic [15:0]       sr_q,
    input  logic              a7_wr,
    input  logic [ADDR_W-1:0] a7_wdata,
    output logic [ADDR_W-1:0] a7_q,
    input  logic              cr_wr,
    input  logic              cr_rd,
    input  logic [CRN_W-1:0]  cr_num,
    input  logic [ADDR_W-1:0] cr_wdata,
    output logic [ADDR_W-1:0] cr_rdata,
    output logic              cr_illegal
);
    logic [SR_W-1:0]   sr_n;
    logic [ADDR_W-1:0] usp_q, isp_q, msp_q;
    cr_sel_e           cr_sel;
    logic              exc_go, sr_go, a7_go, cr_go, vb_go;

    // Priority resolution
    assign exc_go = exc_entry;
    assign sr_go  = !exc_entry && sr_wr;
    assign a7_go  = !exc_entry && a7_wr;
    assign cr_go  = !exc_entry && !sr_wr && !a7_wr && cr_wr && (cr_sel != SEL_NONE);
    assign vb_go  = cr_go && (cr_sel == SEL_VBASE);

    msb_status_reg u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .exc_go   (exc_go),
        .sr_go    (sr_go),
        .sr_wdata (sr_wdata),
        .sr_q     (sr_q),
        .sr_n     (sr_n)
    );

    msb_sp_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .old_s    (sr_q[S_BIT]),
        .old_m    (sr_q[M_BIT]),
        .new_s    (sr_n[S_BIT]),
        .new_m    (sr_n[M_BIT]),
        .exc_go   (exc_go),
        .sr_go    (sr_go),
        .a7_go    (a7_go),
        .a7_wdata (a7_wdata),
        .cr_go    (cr_go),
        .cr_sel   (cr_sel),
        .cr_wdata (cr_wdata),
        .a7_q     (a7_q),
        .usp_q    (usp_q),
        .isp_q    (isp_q),
        .msp_q    (msp_q)
    );

    msb_ctrl_regs #(.ADDR_W(ADDR_W), .CRN_W(CRN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cr_num     (cr_num),
        .cr_rd      (cr_rd),
        .cr_wr      (cr_wr),
        .vb_go      (vb_go),
        .cr_wdata   (cr_wdata),
        .cur_s      (sr_q[S_BIT]),
        .cur_m      (sr_q[M_BIT]),
        .a7_q       (a7_q),
        .usp_q      (usp_q),
        .isp_q      (isp_q),
        .msp_q      (msp_q),
        .cr_sel     (cr_sel),
        .cr_rdata   (cr_rdata),
        .cr_illegal (cr_illegal)
    );
endmodule

// File: rtl/msb_checker.sv
// Checker: temporal properties on the ports of mode_stack_bank.
// Assumes the synchronous active-low reset of the design.
module msb_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exc_entry,
    input logic              sr_wr,
    input logic [15:0]       sr_q,
    input logic              a7_wr,
    input logic [ADDR_W-1:0] a7_q,
    input logic              cr_wr,
    input logic [ADDR_W-1:0] cr_rdata,
    input logic              cr_illegal
);
    logic rst_prev_low;

    // Remember that the previous edge was in reset
    always_ff @(posedge clk) rst_prev_low <= !rst_n;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_prev_low |-> (sr_q == 16'h2700) && (a7_q == '0));

    // R2
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_q & 16'h08E0) == 16'h0000);

    // R11
    exc_entry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> (sr_q[15:12] == 4'b0010));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_entry && !sr_wr && !a7_wr && !cr_wr) |=> ($stable(a7_q) && $stable(sr_q)));

    // R10
    illegal_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_illegal |-> (cr_rdata == '0));

    // R10
    illegal_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr && cr_illegal && !exc_entry && !sr_wr && !a7_wr) |=> ($stable(a7_q) && $stable(sr_q)));
endmodule

bind mode_stack_bank msb_checker #(.ADDR_W(ADDR_W)) u_msb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_entry  (exc_entry),
    .sr_wr      (sr_wr),
    .sr_q       (sr_q),
    .a7_wr      (a7_wr),
    .a7_q       (a7_q),
    .cr_wr      (cr_wr),
    .cr_rdata   (cr_rdata),
    .cr_illegal (cr_illegal)
);

// File: tb/test_mode_stack_bank.sv
// Bench: directed corner cases then seeded random operations, each compared
// against a model of the requirements held in bench variables.
module test_mode_stack_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_entry = 1'b0;
    logic        sr_wr = 1'b0;
    logic [15:0] sr_wdata = '0;
    logic [15:0] sr_q;
    logic        a7_wr = 1'b0;
    logic [31:0] a7_wdata = '0;
    logic [31:0] a7_q;
    logic        cr_wr = 1'b0;
    logic        cr_rd = 1'b0;
    logic [11:0] cr_num = '0;
    logic [31:0] cr_wdata = '0;
    logic [31:0] cr_rdata;
    logic        cr_illegal;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Model state
    logic [15:0] m_sr;
    logic [31:0] m_a7, m_usp, m_isp, m_msp, m_vb;

    always #10 clk = ~clk;

    mode_stack_bank i_mode_stack_bank (
        .clk(clk), .rst_n(rst_n), .exc_entry(exc_entry),
        .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_q(sr_q),
        .a7_wr(a7_wr), .a7_wdata(a7_wdata), .a7_q(a7_q),
        .cr_wr(cr_wr), .cr_rd(cr_rd), .cr_num(cr_num), .cr_wdata(cr_wdata),
        .cr_rdata(cr_rdata), .cr_illegal(cr_illegal)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Expected read value of each control number (R8)
    function automatic logic [31:0] exp_read(input logic [11:0] n);
        logic s, m;
        s = m_sr[13];
        m = m_sr[12];
        case (n)
            12'h800: return !s ? m_a7 : m_usp;
            12'h801: return m_vb;
            12'h803: return (s && m) ? m_a7 : m_msp;
            12'h804: return (s && !m) ? m_a7 : m_isp;
            default: return 32'h0;
        endcase
    endfunction

    // Model update following the requirements
    task automatic model_step(input bit ex, input bit sw, input logic [15:0] sd,
                              input bit aw, input logic [31:0] ad,
                              input bit cw, input logic [11:0] cn, input logic [31:0] cd);
        logic os, om, ns, nm;
        logic [15:0] nsr;
        os = m_sr[13];
        om = m_sr[12];
        if (ex) begin
            if (!os) begin
                m_usp = m_a7;
                m_a7  = om ? m_msp : m_isp;
            end
            m_sr = (m_sr & 16'h0FFF) | 16'h2000;
        end else begin
            if (sw) begin
                nsr = sd & 16'hF71F;
                ns = nsr[13];
                nm = nsr[12];
                if (os && !ns) begin
                    if (om) m_msp = m_a7; else m_isp = m_a7;
                    m_a7 = m_usp;
                end else if (!os && ns) begin
                    m_usp = m_a7;
                    m_a7  = nm ? m_msp : m_isp;
                end else if (os && om != nm) begin
                    if (om) begin m_msp = m_a7; m_a7 = m_isp; end
                    else    begin m_isp = m_a7; m_a7 = m_msp; end
                end
                m_sr = nsr;
            end
            if (aw) m_a7 = ad;
            if (!sw && !aw && cw) begin
                case (cn)
                    12'h800: begin m_usp = cd; if (!os) m_a7 = cd; end
                    12'h801: m_vb = cd;
                    12'h803: begin m_msp = cd; if (os && om) m_a7 = cd; end
                    12'h804: begin m_isp = cd; if (os && !om) m_a7 = cd; end
                    default: ;
                endcase
            end
        end
    endtask

    // Compare outputs and all control reads against the model (sampled at negedge)
    task automatic compare_all(input string tag);
        check(tag, "sr_q", {16'h0, sr_q}, {16'h0, m_sr});
        check(tag, "a7_q", a7_q, m_a7);
        check("R2", "unused sr bits", {16'h0, sr_q & 16'h08E0}, 32'h0);
        cr_rd = 1'b1;
        foreach (exp_read_nums[k]) begin
            cr_num = exp_read_nums[k];
            #1;
            check(tag, $sformatf("read %h", cr_num), cr_rdata, exp_read(cr_num));
            check("R10", $sformatf("illegal flag %h", cr_num), {31'h0, cr_illegal},
                  {31'h0, !(cr_num inside {12'h800, 12'h801, 12'h803, 12'h804})});
        end
        cr_rd = 1'b0;
        cr_num = '0;
    endtask

    logic [11:0] exp_read_nums [6] = '{12'h800, 12'h801, 12'h803, 12'h804, 12'h802, 12'h000};

    // One operation: drive at negedge, clear at next negedge, then compare
    task automatic do_op(input string tag, input bit ex, input bit sw, input logic [15:0] sd,
                         input bit aw, input logic [31:0] ad,
                         input bit cw, input logic [11:0] cn, input logic [31:0] cd);
        @(negedge clk);
        exc_entry = ex; sr_wr = sw; sr_wdata = sd; a7_wr = aw; a7_wdata = ad;
        cr_wr = cw; cr_num = cn; cr_wdata = cd;
        model_step(ex, sw, sd, aw, ad, cw, cn, cd);
        @(negedge clk);
        exc_entry = 1'b0; sr_wr = 1'b0; a7_wr = 1'b0; cr_wr = 1'b0;
        compare_all(tag);
    endtask

    // Watchdog
    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_sr = 16'h2700; m_a7 = 0; m_usp = 0; m_isp = 0; m_msp = 0; m_vb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        compare_all("R1");

        // R9 fill banks through the control port (supervisor, M=0: interrupt bank active)
        do_op("R9", 0, 0, 0, 0, 0, 1, 12'h804, 32'h0000_1000);
        do_op("R9", 0, 0, 0, 0, 0, 1, 12'h803, 32'h0000_2000);
        do_op("R9", 0, 0, 0, 0, 0, 1, 12'h800, 32'h0000_3000);
        do_op("R8", 0, 0, 0, 0, 0, 1, 12'h801, 32'h0000_0400);
        // R10 illegal write has no effect
        do_op("R10", 0, 0, 0, 0, 0, 1, 12'h802, 32'hDEAD_BEEF);
        // R5 M toggle in supervisor, both ways
        do_op("R5", 0, 1, 16'h3000, 0, 0, 0, 0, 0);
        do_op("R5", 0, 1, 16'h2000, 0, 0, 0, 0, 0);
        // R5 no mode change
        do_op("R5", 0, 1, 16'h271F, 0, 0, 0, 0, 0);
        // R3 S 1->0 with M=0, then R4 back to master
        do_op("R3", 0, 1, 16'h0000, 0, 0, 0, 0, 0);
        do_op("R7", 0, 0, 0, 1, 32'h0000_3300, 0, 0, 0);
        do_op("R4", 0, 1, 16'h3000, 0, 0, 0, 0, 0);
        // R3 S 1->0 with M=1
        do_op("R3", 0, 1, 16'h10FF, 0, 0, 0, 0, 0);
        // R9 user write while user active
        do_op("R9", 0, 0, 0, 0, 0, 1, 12'h800, 32'h0000_5000);
        // R11 exception from user with M=1
        do_op("R11", 1, 0, 0, 0, 0, 0, 0, 0);
        // R6 status + A7 same cycle
        do_op("R6", 0, 1, 16'h0000, 1, 32'h0000_7700, 0, 0, 0);
        // R12 exception beats status/A7 write, status beats control write
        do_op("R12", 1, 1, 16'h0000, 1, 32'h1111_1111, 0, 0, 0);
        do_op("R12", 0, 1, 16'h3000, 0, 0, 1, 12'h801, 32'h0BAD_0000);
        // R11 exception from master supervisor: M cleared, A7 kept
        do_op("R11", 1, 0, 0, 0, 0, 0, 0, 0);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int r, c;
            bit ex, sw, aw, cw;
            logic [11:0] cn;
            r = $urandom % 16;
            ex = (r == 0);
            sw = (r >= 1 && r <= 5);
            aw = (r >= 4 && r <= 8);
            cw = (r >= 7);
            c = $urandom % 5;
            case (c)
                0: cn = 12'h800;
                1: cn = 12'h801;
                2: cn = 12'h803;
                3: cn = 12'h804;
                default: cn = 12'($urandom % 4096);
            endcase
            do_op(ex ? "R11" : (sw && aw) ? "R6" : sw ? "R5" : aw ? "R7" : cw ? "R9" : "R7",
                  ex, sw, 16'($urandom), aw, $urandom, cw, cn, $urandom);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule